// File: doc/BRIEF.md
# Control Register Write Validator

This block owns five 64-bit control registers: CR0, CR2, CR3, CR4 and CR8. It judges every request to overwrite one of them. A request is a single-cycle strobe that carries a 4-bit register index, the proposed 64-bit value, the present extended-feature register contents and a flag that says whether the core runs in long mode.

For each request the block decides one of three outcomes:
- the index names no register, so it raises an undefined-opcode fault;
- the value breaks a rule for the chosen register, so it raises a protection fault;
- the write is legal, so it stores the value.

Some of the rules couple bits inside one value. Others look at state outside the value: the CR4 the block currently holds, the long-mode-enable bit of the extended-feature register, and the long-mode flag.

The outcome shows on the clock edge after the strobe. On that edge one register changes or one fault output pulses for a single cycle. The five register values are always visible as outputs, so surrounding logic can read them.

Top module: `cr_write_guard`

## Requirements
- R1: A request with index 1, 5, 6, 7 or any index from 9 to 15 sets `fault_ud` for one cycle on the next edge. No register changes.
- R2: A request with index 0 whose value has any bit in 63:32 set sets `fault_gp` on the next edge instead of writing.
- R3: A request with index 0 whose value has bit 31 (paging enable) set and bit 0 (protection enable) clear sets `fault_gp`.
- R4: A request with index 0 whose value has bit 29 (no write-through) set and bit 30 (cache disable) clear sets `fault_gp`.
- R5: A request with index 0 that sets bit 31 is rejected with `fault_gp` when bit 8 of `efer_in` is set and bit 5 of the CR4 held at the time of the request is clear.
- R6: A request with index 4 whose value has any bit in 63:11 set sets `fault_gp`.
- R7: A request with index 4 whose value clears bit 5 while `long_mode` is high sets `fault_gp`.
- R8: A request with index 8 whose value has any bit in 63:4 set sets `fault_gp`.
- R9: Requests with index 2 or 3 always store the value unchanged.
- R10: On the edge after a request, exactly one of these happens: the selected register is written, or a single one-cycle fault pulse appears. A faulting request leaves all five registers unchanged. A cycle with no request produces no fault and no write.
- R11: Reset sets CR0 to 0x0000_0000_6000_0010 and CR2, CR3, CR4 and CR8 to zero, with both fault outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle write request strobe |
| wr_idx | input | 4 | Target control register index |
| wr_data | input | 64 | Proposed register value |
| efer_in | input | 64 | Current extended-feature register; bit 8 is long-mode enable |
| long_mode | input | 1 | Core currently executes in long mode |
| fault_ud | output | 1 | Undefined-opcode fault pulse |
| fault_gp | output | 1 | Protection fault pulse |
| cr0 | output | 64 | Held CR0 |
| cr2 | output | 64 | Held CR2 |
| cr3 | output | 64 | Held CR3 |
| cr4 | output | 64 | Held CR4 |
| cr8 | output | 64 | Held CR8 |

## Verification
A CR4 commit and the CR0 paging interlock that reads CR4 can meet in one cycle. The new CR4 lands on the same edge where a CR0 request presented right behind it is sampled. The bench provokes this in two steps. First it writes CR4 with the PAE bit clear. On the very next cycle, with no idle gap, it requests CR0 with paging on while long-mode enable is set. The second request must be judged against the freshly stored CR4, so it must fault and leave CR0 unchanged. A separate back-to-back pair re-enables PAE and then expects the paging write to commit.

// File: rtl/cr_write_guard.sv
module cr_write_guard #(
  parameter logic [63:0] CR0_RESET = 64'h0000_0000_6000_0010
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_idx,
  input  logic [63:0] wr_data,
  input  logic [63:0] efer_in,
  input  logic        long_mode,
  output logic        fault_ud,
  output logic        fault_gp,
  output logic [63:0] cr0,
  output logic [63:0] cr2,
  output logic [63:0] cr3,
  output logic [63:0] cr4,
  output logic [63:0] cr8
);
  localparam int PE  = 0;
  localparam int NW  = 29;
  localparam int CD  = 30;
  localparam int PG  = 31;
  localparam int LME = 8;
  localparam int PAE = 5;

  logic idx_bad, gp_cr0, gp_cr4, gp_cr8, gp_hit, commit;

  assign idx_bad = (wr_idx == 4'd1) || (wr_idx >= 4'd5 && wr_idx <= 4'd7) || (wr_idx > 4'd8);

  assign gp_cr0 = (|wr_data[63:32])
                | (wr_data[PG] & ~wr_data[PE])
                | (wr_data[NW] & ~wr_data[CD])
                | (wr_data[PG] & efer_in[LME] & ~cr4[PAE]);
  assign gp_cr4 = (|wr_data[63:11]) | (long_mode & ~wr_data[PAE]);
  assign gp_cr8 = |wr_data[63:4];

  always_comb begin
    case (wr_idx)
      4'd0:    gp_hit = gp_cr0;
      4'd4:    gp_hit = gp_cr4;
      4'd8:    gp_hit = gp_cr8;
      default: gp_hit = 1'b0;
    endcase
  end

  assign commit = wr_en & ~idx_bad & ~gp_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_ud <= 1'b0;
      fault_gp <= 1'b0;
      cr0      <= CR0_RESET;
      cr2      <= '0;
      cr3      <= '0;
      cr4      <= '0;
      cr8      <= '0;
    end else begin
      fault_ud <= wr_en & idx_bad;
      fault_gp <= wr_en & ~idx_bad & gp_hit;
      if (commit) begin
        case (wr_idx)
          4'd0:    cr0 <= wr_data;
          4'd2:    cr2 <= wr_data;
          4'd3:    cr3 <= wr_data;
          4'd4:    cr4 <= wr_data;
          4'd8:    cr8 <= wr_data;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cr_write_guard_chk.sv
module cr_write_guard_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [3:0]  wr_idx,
  input logic [63:0] wr_data,
  input logic        fault_ud,
  input logic        fault_gp,
  input logic [63:0] cr0,
  input logic [63:0] cr2,
  input logic [63:0] cr3,
  input logic [63:0] cr4,
  input logic [63:0] cr8
);
  AST_BAD_INDEX_UD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx == 4'd1 || (wr_idx >= 4'd5 && wr_idx <= 4'd7) || wr_idx > 4'd8)) |=> fault_ud); // R1
  AST_CR0_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n) cr0[63:32] == 32'd0); // R2
  AST_CR0_PG_NEEDS_PE: assert property (@(posedge clk) disable iff (!rst_n) cr0[31] |-> cr0[0]); // R3
  AST_CR0_NW_NEEDS_CD: assert property (@(posedge clk) disable iff (!rst_n) cr0[29] |-> cr0[30]); // R4
  AST_CR4_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n) cr4[63:11] == 53'd0); // R6
  AST_CR8_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n) cr8[63:4] == 60'd0); // R8
  AST_CR2_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 4'd2) |=> (cr2 == $past(wr_data))); // R9
  AST_CR3_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 4'd3) |=> (cr3 == $past(wr_data))); // R9
  AST_FAULTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(fault_ud && fault_gp)); // R10
  AST_IDLE_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (!fault_ud && !fault_gp)); // R10
  AST_FAULT_FREEZES_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_ud || fault_gp) |-> ($stable(cr0) && $stable(cr2) && $stable(cr3) && $stable(cr4) && $stable(cr8))); // R10
endmodule

bind cr_write_guard cr_write_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .fault_ud(fault_ud), .fault_gp(fault_gp),
  .cr0(cr0), .cr2(cr2), .cr3(cr3), .cr4(cr4), .cr8(cr8)
);

// File: tb/cr_write_guard_tb.sv
module cr_write_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [63:0] wr_data;
  logic [63:0] efer_in;
  logic        long_mode;
  logic        fault_ud, fault_gp;
  logic [63:0] cr0, cr2, cr3, cr4, cr8;

  cr_write_guard u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .efer_in(efer_in), .long_mode(long_mode), .fault_ud(fault_ud), .fault_gp(fault_gp),
    .cr0(cr0), .cr2(cr2), .cr3(cr3), .cr4(cr4), .cr8(cr8)
  );

  always #10 clk = ~clk;

  typedef struct packed {
    logic [3:0]  idx;
    logic [63:0] data;
    logic [63:0] efer;
    logic        lm;
    logic [1:0]  res;   // 0 commit, 1 ud, 2 gp
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [0:NV-1] = '{
    '{4'd1,  64'h0,                    64'h0,   1'b0, 2'd1, 4'd1},  // R1
    '{4'd5,  64'h1,                    64'h0,   1'b0, 2'd1, 4'd1},  // R1
    '{4'd7,  64'h2,                    64'h0,   1'b0, 2'd1, 4'd1},  // R1
    '{4'd9,  64'h3,                    64'h0,   1'b0, 2'd1, 4'd1},  // R1
    '{4'd15, 64'h4,                    64'h0,   1'b0, 2'd1, 4'd1},  // R1
    '{4'd2,  64'hDEAD_BEEF_CAFE_F00D,  64'h0,   1'b0, 2'd0, 4'd9},  // R9
    '{4'd3,  64'hFFFF_FFFF_FFFF_FFFF,  64'h0,   1'b0, 2'd0, 4'd9},  // R9
    '{4'd0,  64'h0000_0001_0000_0001,  64'h0,   1'b0, 2'd2, 4'd2},  // R2
    '{4'd0,  64'h0000_0000_8000_0000,  64'h0,   1'b0, 2'd2, 4'd3},  // R3
    '{4'd0,  64'h0000_0000_2000_0000,  64'h0,   1'b0, 2'd2, 4'd4},  // R4
    '{4'd0,  64'h0000_0000_8000_0001,  64'h100, 1'b0, 2'd2, 4'd5},  // R5
    '{4'd0,  64'h0000_0000_8000_0001,  64'h0,   1'b0, 2'd0, 4'd5},  // R5
    '{4'd0,  64'h0000_0000_0000_0011,  64'h0,   1'b0, 2'd0, 4'd10}, // R10
    '{4'd4,  64'h0000_0000_0000_0800,  64'h0,   1'b0, 2'd2, 4'd6},  // R6
    '{4'd4,  64'h0000_0000_0000_0020,  64'h0,   1'b1, 2'd0, 4'd7},  // R7
    '{4'd4,  64'h0000_0000_0000_0000,  64'h0,   1'b1, 2'd2, 4'd7},  // R7
    '{4'd0,  64'h0000_0000_8000_0001,  64'h100, 1'b0, 2'd0, 4'd5},  // R5
    '{4'd4,  64'h0000_0000_0000_07FF,  64'h0,   1'b0, 2'd0, 4'd6},  // R6
    '{4'd8,  64'h0000_0000_0000_0010,  64'h0,   1'b0, 2'd2, 4'd8},  // R8
    '{4'd8,  64'h0000_0000_0000_000F,  64'h0,   1'b0, 2'd0, 4'd8},  // R8
    '{4'd0,  64'h0000_0000_6000_0011,  64'h0,   1'b0, 2'd0, 4'd4},  // R4
    '{4'd0,  64'h0000_0000_4000_0001,  64'h0,   1'b0, 2'd0, 4'd4}   // R4
  };

  int checks = 0;
  int failures = 0;
  logic [63:0] m [0:8];

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 9; i++) m[i] = 64'h0;
    m[0] = 64'h0000_0000_6000_0010;
  endtask

  task automatic chk_regs(input string req);
    chk(req, "cr0", cr0, m[0]);
    chk(req, "cr2", cr2, m[2]);
    chk(req, "cr3", cr3, m[3]);
    chk(req, "cr4", cr4, m[4]);
    chk(req, "cr8", cr8, m[8]);
  endtask

  task automatic drive(input logic [3:0] idx, input logic [63:0] d, input logic [63:0] e, input logic lm);
    wr_en = 1'b1; wr_idx = idx; wr_data = d; efer_in = e; long_mode = lm;
  endtask

  task automatic judge(input string req, input logic [3:0] idx, input logic [63:0] d, input logic [1:0] res);
    chk(req, "fault_ud", {63'd0, fault_ud}, {63'd0, res == 2'd1});
    chk(req, "fault_gp", {63'd0, fault_gp}, {63'd0, res == 2'd2});
    if (res == 2'd0) m[idx] = d;
    chk_regs(req);
  endtask

  initial begin
    #(20ns * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0; efer_in = '0; long_mode = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk("R11", "fault_ud", {63'd0, fault_ud}, 64'd0);
    chk("R11", "fault_gp", {63'd0, fault_gp}, 64'd0);
    chk_regs("R11");

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].idx, VECS[i].data, VECS[i].efer, VECS[i].lm);
      @(negedge clk);
      wr_en = 1'b0;
      judge($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].idx, VECS[i].data, VECS[i].res);
      @(negedge clk);
      // R10 pulse lasts one cycle, idle cycle is quiet
      chk("R10", "fault_ud idle", {63'd0, fault_ud}, 64'd0);
      chk("R10", "fault_gp idle", {63'd0, fault_gp}, 64'd0);
      chk_regs("R10");
    end

    // R5 back-to-back: CR4 clears PAE, CR0 paging request judged against the new CR4
    drive(4'd4, 64'h0, 64'h0, 1'b0);
    @(negedge clk);
    judge("R5 b2b cr4", 4'd4, 64'h0, 2'd0);
    drive(4'd0, 64'h8000_0001, 64'h100, 1'b0);
    @(negedge clk);
    wr_en = 1'b0;
    judge("R5 b2b cr0", 4'd0, 64'h8000_0001, 2'd2);
    @(negedge clk);
    drive(4'd4, 64'h20, 64'h0, 1'b0);
    @(negedge clk);
    judge("R5 b2b cr4 pae", 4'd4, 64'h20, 2'd0);
    drive(4'd0, 64'h8000_0001, 64'h100, 1'b0);
    @(negedge clk);
    wr_en = 1'b0;
    judge("R5 b2b cr0 ok", 4'd0, 64'h8000_0001, 2'd0);

    // R1 bad index directly after an accepted write, back to back
    drive(4'd3, 64'h1234, 64'h0, 1'b0);
    @(negedge clk);
    judge("R9 b2b", 4'd3, 64'h1234, 2'd0);
    drive(4'd6, 64'h5555, 64'h0, 1'b0);
    @(negedge clk);
    wr_en = 1'b0;
    judge("R1 b2b", 4'd6, 64'h5555, 2'd1);

    // R11 reset after activity
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    chk_regs("R11 again");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule